// File: doc/BRIEF.md
# Memory access port register front-end with tiled address mapping

This block presents the register set of a 32-bit debug memory access port to a debug-port engine, while the actual memory traffic goes out on a simple one-word request/acknowledge bus. Control (CSW) and target address (TAR) are held locally. Reads and writes of the data word register (DRW) and of the four banked-data registers become single bus transfers. A running transfer offset is kept beside TAR and advances after data-word accesses when the control word asks for it.

Every flat debug address is folded before it leaves the block. Addresses just above a root base fall in a root region, tile 0. Everything beyond the root span is cut into fixed-size numbered tile windows. The bus therefore carries a tile index and a tile-local offset rather than a raw address. Errors from rejected writes, unknown registers or failed transfers collect in a sticky flag. A flush request reads that flag out and clears it.

Top module: `dbg_memport`

## Requirements
- R1: A write of TAR (offset 0x04) loads the target address and sets the running transfer offset to 0.
- R2: A DRW access (offset 0x0C) issues one bus transfer at ({TAR[31:2],2'b00} + running offset). It has the request direction and, for a write, the request data. A read returns the bus read data on rd_data.
- R3: After a DRW transfer without bus error, if CSW[5:4] is non-zero the running offset grows by 2*CSW[1:0]. It does not change when CSW[5:4] is 0 or when the transfer ends with a bus error.
- R4: The banked-data registers at offsets 0x10, 0x14, 0x18 and 0x1C access ({TAR[31:4],4'b0000} + (offset AND 0xC)) and never change the running offset.
- R5: Translation subtracts 0x8000_0000 from the flat address, modulo 2^32. A result below 0x4400_0000 goes out as tile 0 with the result as the offset.
- R6: Any other result has 0x4400_0000 subtracted. The tile is (value >> 26) + 1 and the offset is the value's low 26 bits.
- R7: Reads of BASE (0xF8) return 0x8000_0000 and reads of CFG (0xF4) return 0. Reads of IDR (0xFC) return 0x4477_0002 when port_num is 0 and 0 otherwise.
- R8: A register write while bank_sel is non-zero changes no state, issues no bus transfer and sets the sticky error.
- R9: A read of any offset other than CSW, DRW, the banked-data registers, CFG, BASE and IDR sets the sticky error, and so does a write of any offset other than CSW, TAR, DRW and the banked-data registers. A transfer acknowledged with bus_err set also sets it.
- R10: A flush_req pulse gives flush_ack one cycle later, with flush_err equal to the sticky error (including errors raised in the flush cycle). The sticky error is then clear.
- R11: At most one bus transfer is outstanding. req_ready is low from acceptance of a bus access until its acknowledge, and bus_req holds with stable tile and offset until bus_ack. resp_valid pulses one cycle after acceptance for local registers, and one cycle after bus_ack for bus accesses.
- R12: After reset CSW, TAR, the running offset and the sticky error are 0 and req_ready is high. A CSW read returns the last accepted CSW write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 8 | Register offset |
| req_wdata | input | 32 | Register write data |
| bank_sel | input | 4 | Selected register bank |
| port_num | input | 8 | Number of the addressed access port |
| req_ready | output | 1 | Block can accept a request |
| resp_valid | output | 1 | Access complete |
| rd_data | output | 32 | Read data, valid with resp_valid |
| flush_req | input | 1 | Return and clear sticky error |
| flush_ack | output | 1 | Flush result valid |
| flush_err | output | 1 | Sticky error state returned by flush |
| bus_req | output | 1 | Bus transfer request |
| bus_write | output | 1 | Bus transfer direction |
| bus_tile | output | 6 | Tile index |
| bus_offset | output | 32 | Tile-local byte offset |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus transfer done |
| bus_rdata | input | 32 | Bus read data |
| bus_err | input | 1 | Bus transfer failed |

## Verification
The bench drives target addresses at the edges of the root region, at the first and last tile windows, and below the root base where the subtraction wraps. A translator with an off-by-one tile or a wrong comparison would route those words to the wrong tile. Sequences of data-word accesses under each increment setting and transfer size check that the offset advances only when it should. A fault address returns a bus error, so a design that advances after a failed transfer re-targets the wrong word on the retry. Writes in a non-zero bank are followed by a CSW read back. Flushes are issued twice in a row to catch a flag that never clears or was never set.

// File: rtl/dbg_memport_pkg.sv
package dbg_memport_pkg;

   localparam logic [7:0] OFS_CSW  = 8'h00;
   localparam logic [7:0] OFS_TAR  = 8'h04;
   localparam logic [7:0] OFS_DRW  = 8'h0C;
   localparam logic [7:0] OFS_CFG  = 8'hF4;
   localparam logic [7:0] OFS_BASE = 8'hF8;
   localparam logic [7:0] OFS_IDR  = 8'hFC;

   typedef enum logic [2:0] {
      K_CSW, K_TAR, K_DRW, K_BD, K_CFG, K_BASE, K_IDR, K_BAD
   } reg_kind_e;

   typedef enum logic {ST_IDLE, ST_BUS} ctl_state_e;

   function automatic reg_kind_e decode_reg(input logic [7:0] ofs);
      reg_kind_e k;
      if (ofs[7:4] == 4'h1 && ofs[1:0] == 2'b00) k = K_BD;
      else begin
         case (ofs)
            OFS_CSW:  k = K_CSW;
            OFS_TAR:  k = K_TAR;
            OFS_DRW:  k = K_DRW;
            OFS_CFG:  k = K_CFG;
            OFS_BASE: k = K_BASE;
            OFS_IDR:  k = K_IDR;
            default:  k = K_BAD;
         endcase
      end
      return k;
   endfunction

endpackage

// File: rtl/dbg_memport_xlate.sv
module dbg_memport_xlate #(
   parameter int unsigned         WORD_W     = 32,
   parameter int unsigned         TILE_W     = 6,
   parameter int unsigned         TILE_SHIFT = 26,
   parameter logic [WORD_W-1:0]   ROOT_BASE  = 32'h8000_0000,
   parameter logic [WORD_W-1:0]   ROOT_SPAN  = 32'h4400_0000
) (
   input  logic [WORD_W-1:0] flat_addr,
   output logic [TILE_W-1:0] tile,
   output logic [WORD_W-1:0] offset
);
   localparam logic [WORD_W-1:0] WIN_MASK = (WORD_W'(1) << TILE_SHIFT) - WORD_W'(1);

   logic [WORD_W-1:0] local_a;
   logic [WORD_W-1:0] beyond;
   logic [WORD_W-1:0] win_idx;

   always_comb begin
      local_a = flat_addr - ROOT_BASE;
      beyond  = local_a - ROOT_SPAN;
      win_idx = (beyond >> TILE_SHIFT) + WORD_W'(1);
      if (local_a < ROOT_SPAN) begin
         tile   = '0;
         offset = local_a;
      end else begin
         tile   = win_idx[TILE_W-1:0];
         offset = beyond & WIN_MASK;
      end
   end
endmodule

// File: rtl/dbg_memport_regs.sv
module dbg_memport_regs #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned INC_LSB = 4,
   parameter int unsigned INC_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csw_we,
   input  logic              tar_we,
   input  logic              inc_en,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] csw,
   output logic [WORD_W-1:0] drw_addr,
   output logic [WORD_W-1:0] bd_base
);
   logic [WORD_W-1:0] csw_q, tar_q, run_off_q;
   logic [WORD_W-1:0] step;

   generate
      if (INC_W == 0) begin : g_no_inc
         assign step = '0;
      end else begin : g_inc
         assign step = (csw_q[INC_LSB +: INC_W] != '0)
                       ? {{(WORD_W-3){1'b0}}, csw_q[1:0], 1'b0} : '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csw_q     <= '0;
         tar_q     <= '0;
         run_off_q <= '0;
      end else begin
         if (csw_we) csw_q <= wdata;
         if (tar_we) begin
            tar_q     <= wdata;
            run_off_q <= '0;
         end else if (inc_en) begin
            run_off_q <= run_off_q + step;
         end
      end
   end

   assign csw      = csw_q;
   assign drw_addr = {tar_q[WORD_W-1:2], 2'b00} + run_off_q;
   assign bd_base  = {tar_q[WORD_W-1:4], 4'b0000};
endmodule

// File: rtl/dbg_memport_ctl.sv
module dbg_memport_ctl
   import dbg_memport_pkg::*;
#(
   parameter int unsigned       WORD_W    = 32,
   parameter int unsigned       TILE_W    = 6,
   parameter logic [WORD_W-1:0] ROOT_BASE = 32'h8000_0000,
   parameter logic [WORD_W-1:0] IDR_VALUE = 32'h4477_0002
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [7:0]        req_reg,
   input  logic [WORD_W-1:0] req_wdata,
   input  logic [3:0]        bank_sel,
   input  logic [7:0]        port_num,
   output logic              req_ready,
   output logic              resp_valid,
   output logic [WORD_W-1:0] rd_data,
   input  logic              flush_req,
   output logic              flush_ack,
   output logic              flush_err,
   input  logic [WORD_W-1:0] csw,
   input  logic [WORD_W-1:0] drw_addr,
   input  logic [WORD_W-1:0] bd_base,
   output logic              csw_we,
   output logic              tar_we,
   output logic              inc_en,
   output logic [WORD_W-1:0] xl_addr,
   input  logic [TILE_W-1:0] xl_tile,
   input  logic [WORD_W-1:0] xl_off,
   output logic              bus_req,
   output logic              bus_write,
   output logic [TILE_W-1:0] bus_tile,
   output logic [WORD_W-1:0] bus_offset,
   output logic [WORD_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic [WORD_W-1:0] bus_rdata,
   input  logic              bus_err
);
   ctl_state_e        state_q;
   reg_kind_e         kind;
   logic              accept, err_ev, start_bus, bus_done;
   logic [WORD_W-1:0] imm_rd;
   logic              is_drw_q, bus_req_q, bus_write_q;
   logic [TILE_W-1:0] tile_q;
   logic [WORD_W-1:0] off_q, wdata_q, rd_q;
   logic              resp_q, sticky_q, fack_q, ferr_q;

   always_comb begin
      kind      = decode_reg(req_reg);
      accept    = req_valid && (state_q == ST_IDLE);
      bus_done  = (state_q == ST_BUS) && bus_ack;
      csw_we    = 1'b0;
      tar_we    = 1'b0;
      inc_en    = 1'b0;
      err_ev    = 1'b0;
      start_bus = 1'b0;
      imm_rd    = '0;
      xl_addr   = (kind == K_BD)
                  ? bd_base + {{(WORD_W-4){1'b0}}, req_reg[3:2], 2'b00}
                  : drw_addr;
      if (accept) begin
         if (req_write) begin
            if (bank_sel != 4'd0) err_ev = 1'b1;
            else begin
               case (kind)
                  K_CSW:       csw_we    = 1'b1;
                  K_TAR:       tar_we    = 1'b1;
                  K_DRW, K_BD: start_bus = 1'b1;
                  default:     err_ev    = 1'b1;
               endcase
            end
         end else begin
            case (kind)
               K_CSW:       imm_rd    = csw;
               K_CFG:       imm_rd    = '0;
               K_BASE:      imm_rd    = ROOT_BASE;
               K_IDR:       imm_rd    = (port_num == 8'd0) ? IDR_VALUE : '0;
               K_DRW, K_BD: start_bus = 1'b1;
               default:     err_ev    = 1'b1;
            endcase
         end
      end
      if (bus_done) begin
         if (bus_err) err_ev = 1'b1;
         else         inc_en = is_drw_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         is_drw_q    <= 1'b0;
         bus_req_q   <= 1'b0;
         bus_write_q <= 1'b0;
         tile_q      <= '0;
         off_q       <= '0;
         wdata_q     <= '0;
         rd_q        <= '0;
         resp_q      <= 1'b0;
      end else begin
         resp_q <= 1'b0;
         if (accept) begin
            if (start_bus) begin
               state_q     <= ST_BUS;
               bus_req_q   <= 1'b1;
               bus_write_q <= req_write;
               is_drw_q    <= (kind == K_DRW);
               tile_q      <= xl_tile;
               off_q       <= xl_off;
               wdata_q     <= req_wdata;
            end else begin
               resp_q <= 1'b1;
               rd_q   <= imm_rd;
            end
         end else if (bus_done) begin
            state_q   <= ST_IDLE;
            bus_req_q <= 1'b0;
            resp_q    <= 1'b1;
            rd_q      <= bus_write_q ? '0 : bus_rdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= 1'b0;
         fack_q   <= 1'b0;
         ferr_q   <= 1'b0;
      end else begin
         fack_q <= flush_req;
         if (flush_req) begin
            ferr_q   <= sticky_q | err_ev;
            sticky_q <= 1'b0;
         end else if (err_ev) begin
            sticky_q <= 1'b1;
         end
      end
   end

   assign req_ready  = (state_q == ST_IDLE);
   assign resp_valid = resp_q;
   assign rd_data    = rd_q;
   assign flush_ack  = fack_q;
   assign flush_err  = ferr_q;
   assign bus_req    = bus_req_q;
   assign bus_write  = bus_write_q;
   assign bus_tile   = tile_q;
   assign bus_offset = off_q;
   assign bus_wdata  = wdata_q;
endmodule

// File: rtl/dbg_memport.sv
module dbg_memport #(
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned TILE_W     = 6,
   parameter int unsigned TILE_SHIFT = 26,
   parameter int unsigned INC_LSB    = 4,
   parameter int unsigned INC_W      = 2,
   parameter logic [WORD_W-1:0] ROOT_BASE = 32'h8000_0000,
   parameter logic [WORD_W-1:0] ROOT_SPAN = 32'h4400_0000,
   parameter logic [WORD_W-1:0] IDR_VALUE = 32'h4477_0002
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [7:0]        req_reg,
   input  logic [WORD_W-1:0] req_wdata,
   input  logic [3:0]        bank_sel,
   input  logic [7:0]        port_num,
   output logic              req_ready,
   output logic              resp_valid,
   output logic [WORD_W-1:0] rd_data,
   input  logic              flush_req,
   output logic              flush_ack,
   output logic              flush_err,
   output logic              bus_req,
   output logic              bus_write,
   output logic [TILE_W-1:0] bus_tile,
   output logic [WORD_W-1:0] bus_offset,
   output logic [WORD_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic [WORD_W-1:0] bus_rdata,
   input  logic              bus_err
);
   localparam int unsigned WIN_BITS = WORD_W - TILE_SHIFT;

   generate
      if (TILE_SHIFT < 4 || TILE_SHIFT >= WORD_W) begin : g_bad_shift
         $error("dbg_memport: TILE_SHIFT out of range");
      end
      if (TILE_W < WIN_BITS) begin : g_bad_tile
         $error("dbg_memport: TILE_W too narrow for the window count");
      end
      if (INC_LSB + INC_W > WORD_W || INC_LSB < 2) begin : g_bad_inc
         $error("dbg_memport: increment field misplaced");
      end
   endgenerate

   logic              csw_we, tar_we, inc_en;
   logic [WORD_W-1:0] csw, drw_addr, bd_base, xl_addr, xl_off;
   logic [TILE_W-1:0] xl_tile;

   dbg_memport_regs #(
      .WORD_W(WORD_W), .INC_LSB(INC_LSB), .INC_W(INC_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .csw_we(csw_we), .tar_we(tar_we),
      .inc_en(inc_en), .wdata(req_wdata), .csw(csw),
      .drw_addr(drw_addr), .bd_base(bd_base)
   );

   dbg_memport_xlate #(
      .WORD_W(WORD_W), .TILE_W(TILE_W), .TILE_SHIFT(TILE_SHIFT),
      .ROOT_BASE(ROOT_BASE), .ROOT_SPAN(ROOT_SPAN)
   ) i_xlate (
      .flat_addr(xl_addr), .tile(xl_tile), .offset(xl_off)
   );

   dbg_memport_ctl #(
      .WORD_W(WORD_W), .TILE_W(TILE_W),
      .ROOT_BASE(ROOT_BASE), .IDR_VALUE(IDR_VALUE)
   ) i_ctl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_reg(req_reg),
      .req_wdata(req_wdata), .bank_sel(bank_sel), .port_num(port_num),
      .req_ready(req_ready), .resp_valid(resp_valid), .rd_data(rd_data),
      .flush_req(flush_req), .flush_ack(flush_ack), .flush_err(flush_err),
      .csw(csw), .drw_addr(drw_addr), .bd_base(bd_base),
      .csw_we(csw_we), .tar_we(tar_we), .inc_en(inc_en),
      .xl_addr(xl_addr), .xl_tile(xl_tile), .xl_off(xl_off),
      .bus_req(bus_req), .bus_write(bus_write), .bus_tile(bus_tile),
      .bus_offset(bus_offset), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err)
   );
endmodule

// File: rtl/dbg_memport_chk.sv
module dbg_memport_chk #(
   parameter int unsigned       WORD_W     = 32,
   parameter int unsigned       TILE_W     = 6,
   parameter int unsigned       TILE_SHIFT = 26,
   parameter logic [WORD_W-1:0] ROOT_SPAN  = 32'h4400_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              resp_valid,
   input logic              flush_req,
   input logic              flush_ack,
   input logic              bus_req,
   input logic [TILE_W-1:0] bus_tile,
   input logic [WORD_W-1:0] bus_offset,
   input logic              bus_ack
);
   localparam logic [WORD_W-1:0] WIN_SIZE = WORD_W'(1) << TILE_SHIFT;

   // R11: bus request holds until acknowledged
   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req);

   // R11: tile and offset stay put while waiting
   p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> $stable(bus_tile) && $stable(bus_offset));

   // R11: no new request accepted while a transfer is outstanding
   p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> !req_ready);

   // R11: acknowledge completes the access on the next cycle
   p_ack_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ack |=> resp_valid && !bus_req);

   // R5: root-region offsets stay below the root span
   p_root_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_tile == '0 |-> bus_offset < ROOT_SPAN);

   // R6: tile-window offsets stay inside one window
   p_win_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_tile != '0 |-> bus_offset < WIN_SIZE);

   // R10: flush answered on the next cycle
   p_flush_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |=> flush_ack);
endmodule

bind dbg_memport dbg_memport_chk #(
   .WORD_W(WORD_W), .TILE_W(TILE_W), .TILE_SHIFT(TILE_SHIFT), .ROOT_SPAN(ROOT_SPAN)
) i_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
   .flush_req(flush_req), .flush_ack(flush_ack), .bus_req(bus_req),
   .bus_tile(bus_tile), .bus_offset(bus_offset), .bus_ack(bus_ack)
);

// File: tb/test_dbg_memport.sv
module test_dbg_memport;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_reg = '0, port_num = '0;
   logic [31:0] req_wdata = '0;
   logic [3:0]  bank_sel = '0;
   logic        req_ready, resp_valid, flush_ack, flush_err;
   logic [31:0] rd_data;
   logic        flush_req = 1'b0;
   logic        bus_req, bus_write;
   logic [5:0]  bus_tile;
   logic [31:0] bus_offset, bus_wdata;
   logic        bus_ack = 1'b0, bus_err = 1'b0;
   logic [31:0] bus_rdata = '0;

   int errors = 0, checks = 0;

   always #4 clk = ~clk;

   dbg_memport i_dbg_memport (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_reg(req_reg), .req_wdata(req_wdata), .bank_sel(bank_sel),
      .port_num(port_num), .req_ready(req_ready), .resp_valid(resp_valid),
      .rd_data(rd_data), .flush_req(flush_req), .flush_ack(flush_ack),
      .flush_err(flush_err), .bus_req(bus_req), .bus_write(bus_write),
      .bus_tile(bus_tile), .bus_offset(bus_offset), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err)
   );

   // reference state
   logic [31:0] m_csw = '0, m_tar = '0, m_off = '0;
   bit          m_sticky = 1'b0;

   function automatic void ref_xlate(input logic [31:0] a, output logic [5:0] t,
                                     output logic [31:0] o);
      logic [31:0] l, b;
      l = a - 32'h8000_0000;
      if (l < 32'h4400_0000) begin t = 6'd0; o = l; end
      else begin
         b = l - 32'h4400_0000;
         t = 6'(b / 32'h0400_0000 + 1);
         o = b % 32'h0400_0000;
      end
   endfunction

   function automatic logic [31:0] mem_val(input logic [5:0] t, input logic [31:0] o);
      return (o * 32'h9E37_79B1) ^ {26'd0, t} ^ 32'h1357_0000;
   endfunction

   function automatic bit is_fault(input logic [5:0] t, input logic [31:0] o);
      return (t == 6'd0 && o == 32'h0000_0F00);
   endfunction

   // bus model
   bit          seen = 1'b0, rec_w;
   logic [5:0]  rec_t;
   logic [31:0] rec_o, rec_d;
   int          dly = 0;
   always @(negedge clk) begin
      if (bus_ack) bus_ack = 1'b0;
      else if (bus_req) begin
         if (dly == 0) begin
            bus_ack = 1'b1;
            bus_rdata = mem_val(bus_tile, bus_offset);
            bus_err = is_fault(bus_tile, bus_offset);
            seen = 1'b1; rec_w = bus_write; rec_t = bus_tile;
            rec_o = bus_offset; rec_d = bus_wdata;
            dly = $urandom % 3;
         end else dly = dly - 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic access(input bit w, input logic [7:0] r, input logic [31:0] d,
                         input logic [3:0] bk, input logic [7:0] pn,
                         output logic [31:0] rd);
      bit got = 1'b0;
      seen = 1'b0;
      rd = '0;
      req_valid = 1'b1; req_write = w; req_reg = r; req_wdata = d;
      bank_sel = bk; port_num = pn;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      for (int n = 0; n < 16 && !got; n++) begin
         if (resp_valid) begin got = 1'b1; rd = rd_data; end
         else @(negedge clk);
      end
      chk(got, "R11", "response arrived", 32'(got), 32'd1);
      @(negedge clk);
   endtask

   task automatic local_op(input bit w, input logic [7:0] r, input logic [31:0] d,
                           input logic [3:0] bk, input logic [7:0] pn,
                           input bit exp_err, input bit chk_rd,
                           input logic [31:0] exp_rd, input string tag);
      logic [31:0] rd;
      access(w, r, d, bk, pn, rd);
      chk(!seen, tag, "no bus transfer", 32'(seen), 32'd0);
      if (chk_rd) chk(rd == exp_rd, tag, "read data", rd, exp_rd);
      if (exp_err) m_sticky = 1'b1;
      else if (w && r == 8'h00) m_csw = d;
      else if (w && r == 8'h04) begin m_tar = d; m_off = '0; end
   endtask

   task automatic bus_op(input bit w, input logic [7:0] r, input logic [31:0] d,
                         input string tag);
      logic [31:0] a, eo, rd;
      logic [5:0]  et;
      bit          f;
      if (r == 8'h0C) a = {m_tar[31:2], 2'b00} + m_off;
      else            a = {m_tar[31:4], 4'b0000} + {28'd0, r[3:2], 2'b00};
      ref_xlate(a, et, eo);
      f = is_fault(et, eo);
      access(w, r, d, 4'd0, 8'd0, rd);
      chk(seen, tag, "bus transfer issued", 32'(seen), 32'd1);
      chk(rec_t == et, (et == 0) ? "R5" : "R6", "tile", 32'(rec_t), 32'(et));
      chk(rec_o == eo, (et == 0) ? "R5" : "R6", "offset", rec_o, eo);
      chk(rec_w == w, "R2", "direction", 32'(rec_w), 32'(w));
      if (w) chk(rec_d == d, "R2", "write data", rec_d, d);
      else if (!f) chk(rd == mem_val(et, eo), "R2", "read data", rd, mem_val(et, eo));
      if (f) m_sticky = 1'b1;
      else if (r == 8'h0C && m_csw[5:4] != 2'b00) m_off = m_off + {29'd0, m_csw[1:0], 1'b0};
   endtask

   task automatic flush(input string tag);
      flush_req = 1'b1;
      @(negedge clk);
      flush_req = 1'b0;
      chk(flush_ack, "R10", "flush ack", 32'(flush_ack), 32'd1);
      chk(flush_err == m_sticky, tag, "flush status", 32'(flush_err), 32'(m_sticky));
      m_sticky = 1'b0;
      @(negedge clk);
   endtask

   function automatic logic [31:0] pick_tar();
      case ($urandom % 7)
         0: return 32'h8000_0F00;
         1: return 32'hC3FF_FFF0;
         2: return 32'hC400_0000;
         3: return 32'hFFFF_FFF0;
         4: return 32'h0000_0010;
         5: return 32'h8000_0000 + ($urandom % 32'h4400_0000);
         default: return $urandom;
      endcase
   endfunction

   initial begin
      void'($urandom(32'd2024));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: reset state
      chk(req_ready, "R12", "ready after reset", 32'(req_ready), 32'd1);
      chk(!bus_req && !resp_valid, "R12", "idle outputs", 32'(bus_req), 32'd0);
      local_op(1'b0, 8'h00, 0, 0, 0, 0, 1, 32'd0, "R12");
      flush("R12");

      // R7: constant registers
      local_op(1'b0, 8'hF8, 0, 0, 0, 0, 1, 32'h8000_0000, "R7");
      local_op(1'b0, 8'hF4, 0, 0, 0, 0, 1, 32'd0, "R7");
      local_op(1'b0, 8'hFC, 0, 0, 8'd0, 0, 1, 32'h4477_0002, "R7");
      local_op(1'b0, 8'hFC, 0, 0, 8'd3, 0, 1, 32'd0, "R7");

      // R1/R3: increment by 4 with field set
      local_op(1'b1, 8'h00, 32'h0000_0012, 0, 0, 0, 0, 0, "R12");
      local_op(1'b1, 8'h04, 32'hA000_0003, 0, 0, 0, 0, 0, "R1");
      for (int i = 0; i < 3; i++) bus_op(1'b0, 8'h0C, 0, "R3");
      // R1: TAR write resets the offset
      local_op(1'b1, 8'h04, 32'hA000_0000, 0, 0, 0, 0, 0, "R1");
      bus_op(1'b1, 8'h0C, 32'hCAFE_0001, "R1");
      // R4: banked data does not move the offset
      for (int k = 0; k < 4; k++) bus_op(k[0], 8'h10 + 8'(k * 4), $urandom, "R4");
      bus_op(1'b0, 8'h0C, 0, "R4");
      // R3: field zero means no increment
      local_op(1'b1, 8'h00, 32'h0000_0002, 0, 0, 0, 0, 0, "R3");
      bus_op(1'b0, 8'h0C, 0, "R3");
      bus_op(1'b0, 8'h0C, 0, "R3");
      // R3/R9: bus error leaves offset, raises sticky
      local_op(1'b1, 8'h00, 32'h0000_0022, 0, 0, 0, 0, 0, "R3");
      local_op(1'b1, 8'h04, 32'h8000_0F00, 0, 0, 0, 0, 0, "R9");
      bus_op(1'b0, 8'h0C, 0, "R9");
      bus_op(1'b0, 8'h0C, 0, "R3");
      flush("R9");
      flush("R10");
      // R8: bank non-zero write rejected
      local_op(1'b1, 8'h00, 32'hFFFF_FFFF, 4'd2, 0, 1, 0, 0, "R8");
      local_op(1'b1, 8'h0C, 32'h1234_5678, 4'd1, 0, 1, 0, 0, "R8");
      local_op(1'b0, 8'h00, 0, 0, 0, 0, 1, m_csw, "R8");
      flush("R8");
      // R9: unknown accesses
      local_op(1'b0, 8'h04, 0, 0, 0, 1, 0, 0, "R9");
      flush("R9");
      local_op(1'b1, 8'hF8, 32'h1, 0, 0, 1, 0, 0, "R9");
      local_op(1'b0, 8'h08, 0, 0, 0, 1, 0, 0, "R9");
      flush("R9");

      // random mix
      for (int i = 0; i < 600; i++) begin
         int op;
         op = $urandom % 10;
         case (op)
            0: local_op(1'b1, 8'h00, {$urandom} & 32'h0000_00F3, 0, 0, 0, 0, 0, "R12");
            1: local_op(1'b1, 8'h04, pick_tar(), 0, 0, 0, 0, 0, "R1");
            2, 3: bus_op($urandom % 2, 8'h0C, $urandom, "R2");
            4: bus_op($urandom % 2, 8'h10 + 8'(($urandom % 4) * 4), $urandom, "R4");
            5: local_op(1'b0, 8'h00, 0, 0, 0, 0, 1, m_csw, "R12");
            6: local_op(1'b1, 8'h00, $urandom, 4'(1 + $urandom % 15), 0, 1, 0, 0, "R8");
            7: local_op(1'b0, 8'h30, 0, 0, 0, 1, 0, 0, "R9");
            8: flush("R10");
            default: begin
               logic [7:0] pn;
               pn = 8'($urandom % 3);
               local_op(1'b0, 8'hFC, 0, 0, pn, 0, 1,
                        (pn == 0) ? 32'h4477_0002 : 32'd0, "R7");
            end
         endcase
      end
      flush("R10");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule